// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Flag Update Masks

This block is the purely combinational arithmetic and logic stage of a small 8-bit accumulator processor. Each cycle the sequencer presents a 4-bit operation code, the accumulator value, an operand taken from memory and the current carry flag. The block returns the result byte, a write-back strobe for the destination, four flag values (negative, overflow, zero, carry) and a per-flag update mask. The surrounding status register copies only the masked flags, so every operation changes exactly its own subset of status bits.

Addition and subtraction share one binary adder. Subtraction feeds the inverted operand, so a carry of 1 means that no borrow occurred. Shifts and rotates move the bit that leaves the byte into the carry output, and rotates feed the incoming carry back into the vacated bit. The shift, rotate, increment and decrement operations act on the memory operand port. The sequencer presents the accumulator on that port for the accumulator forms. Decimal arithmetic, operand fetch, addressing and register storage sit outside this block.

Top module: `alu8`

## Requirements
- R1: Operation codes on `op_i` are ADC=0, SBC=1, AND=2, OR=3, XOR=4, CMP=5, BIT=6, ASL=7, LSR=8, ROL=9, ROR=10, INC=11, DEC=12. The bits of `flags_o` and `flag_we_o` are [3]=N, [2]=V, [1]=Z, [0]=C. A flag bit whose enable is 0 reads 0.
- R2: ADC gives result = (acc + operand + carry_i) mod 256. C is the ninth bit of that sum. V is set when both addends have the same sign and the result sign differs. It updates N, V, Z and C and asserts `wr_o`.
- R3: SBC gives result = acc − operand − (1 − carry_i) mod 256. C = 1 when the true difference is not negative. V is set on signed overflow of that difference. It updates N, V, Z and C and asserts `wr_o`.
- R4: AND, OR and XOR give the bitwise result of acc and operand, update only N and Z, and assert `wr_o`.
- R5: CMP gives acc − operand on `result_o` and ignores carry_i. C = 1 when acc ≥ operand as unsigned values. It updates N, Z and C and keeps `wr_o` low.
- R6: BIT sets Z when (acc AND operand) is zero. N and V are copied from operand bits 7 and 6. It updates N, V and Z and keeps `wr_o` low.
- R7: ASL shifts the operand left, moves bit 7 to C and fills bit 0 with 0. LSR shifts right, moves bit 0 to C and fills bit 7 with 0, which makes N 0. Both update N, Z and C.
- R8: ROL moves carry_i into bit 0 and bit 7 into C. ROR moves carry_i into bit 7 and bit 0 into C. Both update N, Z and C.
- R9: INC and DEC give operand + 1 and operand − 1 mod 256, ignore carry_i, and update only N and Z.
- R10: Codes 13 to 15 give result 0, `wr_o` low and all flag enables low.
- R11: For every operation except BIT, an enabled N equals result bit 7 and an enabled Z equals (result == 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Memory operand |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 8 | Result byte |
| wr_o | output | 1 | Result is to be written back |
| flags_o | output | 4 | New N, V, Z, C values |
| flag_we_o | output | 4 | Per-flag update enables |

## Verification
Add and subtract run over a grid of accumulator and operand values with both carry values. The grid crosses the signed and unsigned wrap points, so it separates a correct overflow rule from a carry-out or sign-only rule. It also catches a subtract whose borrow sense is inverted. A table of vectors applies each logic, compare, bit-test, shift and rotate code to bit patterns where only the intended bit source is correct. These patterns set bit 7 against bit 0 and vary the carry in, which exposes a swapped shift direction, a missing rotate feed or a wrong fill bit. Further vectors check the enable mask and `wr_o` for every code, the value of each unenabled flag, the wrap of increment and decrement through zero, and the unused codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int NF = 4;
  localparam int FN = 3;
  localparam int FV = 2;
  localparam int FZ = 1;
  localparam int FC = 0;

  typedef enum logic [3:0] {
    OP_ADC = 4'd0,
    OP_SBC = 4'd1,
    OP_AND = 4'd2,
    OP_ORA = 4'd3,
    OP_EOR = 4'd4,
    OP_CMP = 4'd5,
    OP_BIT = 4'd6,
    OP_ASL = 4'd7,
    OP_LSR = 4'd8,
    OP_ROL = 4'd9,
    OP_ROR = 4'd10,
    OP_INC = 4'd11,
    OP_DEC = 4'd12
  } op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } lg_e;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         ci_i,
  output logic [W-1:0] sum_o,
  output logic         co_o,
  output logic         ovf_o
);
  logic [W:0] full;

  assign full  = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, ci_i};
  assign sum_o = full[W-1:0];
  assign co_o  = full[W];
  // signed overflow: like-signed addends, result sign flipped
  assign ovf_o = (x_i[W-1] == y_i[W-1]) && (full[W-1] != x_i[W-1]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  lg_e          mode_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (mode_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] din_i,
  input  logic         cin_i,
  input  logic         left_i,
  input  logic         rot_i,
  output logic [W-1:0] dout_o,
  output logic         cout_o
);
  logic fill;

  assign fill = rot_i & cin_i;

  always_comb begin
    if (left_i) begin
      dout_o = {din_i[W-2:0], fill};
      cout_o = din_i[W-1];
    end else begin
      dout_o = {fill, din_i[W-1:1]};
      cout_o = din_i[0];
    end
  end
endmodule

// File: rtl/alu8.sv
module alu8
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]    op_i,
  input  logic [W-1:0]  acc_i,
  input  logic [W-1:0]  opnd_i,
  input  logic          carry_i,
  output logic [W-1:0]  result_o,
  output logic          wr_o,
  output logic [NF-1:0] flags_o,
  output logic [NF-1:0] flag_we_o
);
  op_e          op;
  logic [W-1:0] add_x, add_y, add_sum;
  logic         add_ci, add_co, add_ovf;
  lg_e          lg_mode;
  logic [W-1:0] lg_res;
  logic         sh_left, sh_rot, sh_co;
  logic [W-1:0] sh_res;
  logic [W-1:0] res;
  logic         res_n, res_z;

  assign op = op_e'(op_i);

  // adder operand steering; subtraction uses the inverted operand
  always_comb begin
    add_x  = acc_i;
    add_y  = opnd_i;
    add_ci = carry_i;
    unique case (op)
      OP_SBC: add_y = ~opnd_i;
      OP_CMP: begin
        add_y  = ~opnd_i;
        add_ci = 1'b1;
      end
      OP_INC: begin
        add_x  = opnd_i;
        add_y  = '0;
        add_ci = 1'b1;
      end
      OP_DEC: begin
        add_x  = opnd_i;
        add_y  = '1;
        add_ci = 1'b0;
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_ORA:  lg_mode = LG_OR;
      OP_EOR:  lg_mode = LG_XOR;
      default: lg_mode = LG_AND;
    endcase
  end

  assign sh_left = (op == OP_ASL) || (op == OP_ROL);
  assign sh_rot  = (op == OP_ROL) || (op == OP_ROR);

  alu8_arith #(.W(W)) u_arith (
    .x_i   (add_x),
    .y_i   (add_y),
    .ci_i  (add_ci),
    .sum_o (add_sum),
    .co_o  (add_co),
    .ovf_o (add_ovf)
  );

  alu8_logic #(.W(W)) u_logic (
    .mode_i (lg_mode),
    .a_i    (acc_i),
    .b_i    (opnd_i),
    .res_o  (lg_res)
  );

  alu8_shift #(.W(W)) u_shift (
    .din_i  (opnd_i),
    .cin_i  (carry_i),
    .left_i (sh_left),
    .rot_i  (sh_rot),
    .dout_o (sh_res),
    .cout_o (sh_co)
  );

  // result selection
  always_comb begin
    unique case (op)
      OP_ADC, OP_SBC, OP_CMP, OP_INC, OP_DEC: res = add_sum;
      OP_AND, OP_ORA, OP_EOR, OP_BIT:         res = lg_res;
      OP_ASL, OP_LSR, OP_ROL, OP_ROR:         res = sh_res;
      default:                                res = '0;
    endcase
  end

  assign res_n = res[W-1];
  assign res_z = (res == '0);

  // flag values and masks; bit order N V Z C
  always_comb begin
    flags_o   = '0;
    flag_we_o = '0;
    wr_o      = 1'b0;
    unique case (op)
      OP_ADC, OP_SBC: begin
        flags_o   = {res_n, add_ovf, res_z, add_co};
        flag_we_o = 4'b1111;
        wr_o      = 1'b1;
      end
      OP_CMP: begin
        flags_o   = {res_n, 1'b0, res_z, add_co};
        flag_we_o = 4'b1011;
      end
      OP_AND, OP_ORA, OP_EOR, OP_INC, OP_DEC: begin
        flags_o   = {res_n, 1'b0, res_z, 1'b0};
        flag_we_o = 4'b1010;
        wr_o      = 1'b1;
      end
      OP_BIT: begin
        flags_o   = {opnd_i[W-1], opnd_i[W-2], res_z, 1'b0};
        flag_we_o = 4'b1110;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        flags_o   = {res_n, 1'b0, res_z, sh_co};
        flag_we_o = 4'b1011;
        wr_o      = 1'b1;
      end
      default: ;
    endcase
  end

  assign result_o = res;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic [3:0]    op_i,
  input logic [W-1:0]  acc_i,
  input logic [W-1:0]  opnd_i,
  input logic          carry_i,
  input logic [W-1:0]  result_o,
  input logic          wr_o,
  input logic [NF-1:0] flags_o,
  input logic [NF-1:0] flag_we_o
);
  logic [W:0] add_ref;
  logic       is_lgc, is_nowb, is_bad;

  assign add_ref = {1'b0, acc_i} + {1'b0, opnd_i} + {{W{1'b0}}, carry_i};
  assign is_lgc  = (op_i == OP_AND) || (op_i == OP_ORA) || (op_i == OP_EOR) ||
                   (op_i == OP_INC) || (op_i == OP_DEC);
  assign is_nowb = (op_i == OP_CMP) || (op_i == OP_BIT);
  assign is_bad  = (op_i > OP_DEC);

  always_comb begin
    // R1
    idle_flag_chk: assert ((flags_o & ~flag_we_o) == '0);
    if (flag_we_o[FZ]) begin
      // R11
      zero_flag_chk: assert (flags_o[FZ] == (result_o == '0));
    end
    if (flag_we_o[FN] && op_i != OP_BIT) begin
      // R11
      neg_flag_chk: assert (flags_o[FN] == result_o[W-1]);
    end
    if (op_i == OP_ADC) begin
      // R2
      add_sum_chk: assert ({flags_o[FC], result_o} == add_ref);
    end
    if (is_lgc) begin
      // R4
      carry_keep_chk: assert (!flag_we_o[FC] && !flag_we_o[FV]);
    end
    if (is_nowb) begin
      // R5
      no_wb_chk: assert (!wr_o);
    end
    if (is_bad) begin
      // R10
      bad_op_chk: assert (!wr_o && flag_we_o == '0 && result_o == '0);
    end
  end
endmodule

bind alu8 alu8_chk #(.W(W)) chk_i (
  .op_i      (op_i),
  .acc_i     (acc_i),
  .opnd_i    (opnd_i),
  .carry_i   (carry_i),
  .result_o  (result_o),
  .wr_o      (wr_o),
  .flags_o   (flags_o),
  .flag_we_o (flag_we_o)
);

// File: tb/alu8_tb.sv
module alu8_tb_top;
  localparam int NV = 24;
  localparam int VW = 38;

  logic       clk;
  logic       rst_ni;
  logic [3:0] op_i;
  logic [7:0] acc_i, opnd_i;
  logic       carry_i;
  logic [7:0] result_o;
  logic       wr_o;
  logic [3:0] flags_o, flag_we_o;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 0;

  // {op, acc, opnd, cin, result, wr, flags NVZC, enables NVZC}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd0,  8'h50, 8'h50, 1'b0, 8'hA0, 1'b1, 4'b1100, 4'b1111}, // R2 signed overflow
    {4'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 4'b0011, 4'b1111}, // R2 carry out, zero
    {4'd0,  8'h7F, 8'h00, 1'b1, 8'h80, 1'b1, 4'b1100, 4'b1111}, // R2 carry in
    {4'd1,  8'h50, 8'hB0, 1'b1, 8'hA0, 1'b1, 4'b1100, 4'b1111}, // R3 borrow, overflow
    {4'd1,  8'h05, 8'h03, 1'b0, 8'h01, 1'b1, 4'b0001, 4'b1111}, // R3 extra borrow
    {4'd1,  8'h80, 8'h01, 1'b1, 8'h7F, 1'b1, 4'b0101, 4'b1111}, // R3 neg-pos overflow
    {4'd2,  8'hF0, 8'h8F, 1'b1, 8'h80, 1'b1, 4'b1000, 4'b1010}, // R4 and
    {4'd3,  8'h00, 8'h00, 1'b1, 8'h00, 1'b1, 4'b0010, 4'b1010}, // R4 or zero
    {4'd4,  8'hAA, 8'hAA, 1'b1, 8'h00, 1'b1, 4'b0010, 4'b1010}, // R4 xor zero
    {4'd5,  8'h40, 8'h40, 1'b0, 8'h00, 1'b0, 4'b0011, 4'b1011}, // R5 equal, cin ignored
    {4'd5,  8'h10, 8'h20, 1'b1, 8'hF0, 1'b0, 4'b1000, 4'b1011}, // R5 less
    {4'd6,  8'h0F, 8'hC0, 1'b0, 8'h00, 1'b0, 4'b1110, 4'b1110}, // R6 N,V from operand
    {4'd6,  8'hFF, 8'h41, 1'b1, 8'h41, 1'b0, 4'b0100, 4'b1110}, // R6 nonzero
    {4'd7,  8'h00, 8'h81, 1'b1, 8'h02, 1'b1, 4'b0001, 4'b1011}, // R7 asl zero fill
    {4'd8,  8'h00, 8'h01, 1'b1, 8'h00, 1'b1, 4'b0011, 4'b1011}, // R7 lsr to carry
    {4'd8,  8'h00, 8'hFE, 1'b0, 8'h7F, 1'b1, 4'b0000, 4'b1011}, // R7 lsr N forced 0
    {4'd9,  8'h00, 8'h80, 1'b1, 8'h01, 1'b1, 4'b0011 ^ 4'b0010, 4'b1011}, // R8 rol
    {4'd10, 8'h00, 8'h01, 1'b1, 8'h80, 1'b1, 4'b1001, 4'b1011}, // R8 ror
    {4'd10, 8'h00, 8'h02, 1'b0, 8'h01, 1'b1, 4'b0000, 4'b1011}, // R8 ror no carry
    {4'd11, 8'h33, 8'hFF, 1'b0, 8'h00, 1'b1, 4'b0010, 4'b1010}, // R9 inc wrap
    {4'd12, 8'h33, 8'h00, 1'b1, 8'hFF, 1'b1, 4'b1000, 4'b1010}, // R9 dec wrap, cin ignored
    {4'd13, 8'h12, 8'h34, 1'b1, 8'h00, 1'b0, 4'b0000, 4'b0000}, // R10
    {4'd15, 8'hFF, 8'hFF, 1'b1, 8'h00, 1'b0, 4'b0000, 4'b0000}, // R10
    {4'd11, 8'h00, 8'h7F, 1'b1, 8'h80, 1'b1, 4'b1000, 4'b1010}  // R9 inc sign change
  };

  alu8 dut_i (
    .op_i      (op_i),
    .acc_i     (acc_i),
    .opnd_i    (opnd_i),
    .carry_i   (carry_i),
    .result_o  (result_o),
    .wr_o      (wr_o),
    .flags_o   (flags_o),
    .flag_we_o (flag_we_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0:             return "R2";
      4'd1:             return "R3";
      4'd2, 4'd3, 4'd4: return "R4";
      4'd5:             return "R5";
      4'd6:             return "R6";
      4'd7, 4'd8:       return "R7";
      4'd9, 4'd10:      return "R8";
      4'd11, 4'd12:     return "R9";
      default:          return "R10";
    endcase
  endfunction

  task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m,
                       input logic c);
    @(negedge clk);
    op_i = op; acc_i = a; opnd_i = m; carry_i = c;
    #5;
  endtask

  task automatic check(input string req, input logic [7:0] r, input logic w,
                       input logic [3:0] f, input logic [3:0] e);
    n_total++;
    if ({result_o, wr_o, flags_o, flag_we_o} !== {r, w, f, e}) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h m=%h c=%b: got res=%h wr=%b fl=%b we=%b exp res=%h wr=%b fl=%b we=%b",
               req, op_i, acc_i, opnd_i, carry_i, result_o, wr_o, flags_o, flag_we_o,
               r, w, f, e);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    op_i = 4'd0; acc_i = 8'h00; opnd_i = 8'h00; carry_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    // R11 reset state: add of zeros gives zero with only Z set
    apply(4'd0, 8'h00, 8'h00, 1'b0);
    check("R11", 8'h00, 1'b1, 4'b0010, 4'b1111);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      apply(v[37:34], v[33:26], v[25:18], v[17]);
      check(req_of(v[37:34]), v[16:9], v[8], v[7:4], v[3:0]);
    end

    // R1 bit positions: only N set after ror of 0 with carry in
    apply(4'd10, 8'h00, 8'h00, 1'b1);
    check("R1", 8'h80, 1'b1, 4'b1000, 4'b1011);

    // R2 R3 grid against integer arithmetic
    for (int a = 0; a < 256; a += 17) begin
      for (int m = 0; m < 256; m += 23) begin
        for (int c = 0; c < 2; c++) begin
          for (int s = 0; s < 2; s++) begin
            int u, sv, sa, sm;
            logic [7:0] r;
            logic n, vf, z, cf;
            sa = (a > 127) ? a - 256 : a;
            sm = (m > 127) ? m - 256 : m;
            if (s == 0) begin
              u  = a + m + c;
              sv = sa + sm + c;
              cf = (u > 255);
            end else begin
              u  = a - m - (1 - c);
              sv = sa - sm - (1 - c);
              cf = (u >= 0);
            end
            r  = 8'(u & 255);
            n  = r[7];
            z  = (r == 8'h00);
            vf = (sv > 127) || (sv < -128);
            apply(4'(s), 8'(a), 8'(m), 1'(c));
            check((s == 0) ? "R2" : "R3", r, 1'b1, {n, vf, z, cf}, 4'b1111);
          end
        end
      end
    end

    // R5 compare over unsigned ordering, carry_i ignored
    for (int k = 0; k < 8; k++) begin
      logic [7:0] a, m, r;
      a = 8'(k * 37);
      m = 8'(200 - k * 29);
      r = 8'((a - m) & 8'hFF);
      apply(4'd5, a, m, 1'(k));
      check("R5", r, 1'b0, {r[7], 1'b0, r == 8'h00, a >= m}, 4'b1011);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule